// File: doc/BRIEF.md
# Seconds Counter with Alarm Compare

This block keeps a 32-bit count of elapsed time. A slow clock enters as an asynchronous input. It is synchronized into the bus clock domain, and each of its rising edges advances a programmable prescaler. When the prescaler completes a full period, the 32-bit counter increments. If the prescaler is loaded with the slow-clock frequency, the counter steps once per second.

Software reaches the block through a simple synchronous register bus with four word registers:

| Offset | Register | Access |
|--------|----------|--------|
| 0x00 | Control | read/write |
| 0x04 | Alarm | read/write |
| 0x08 | Count | read-only |
| 0x0C | Events | read-to-clear |

Software cannot load the counter. It can only force it back to zero through a one-shot restart bit. Two sticky event flags record increments and alarm matches. The interrupt output is high when a flag is set and its enable bit is also set.

A typical driver keeps the epoch offset elsewhere and adds it to the count. Because the counter steps on a clock the bus does not own, software reads the count twice and trusts the value only when both reads agree.

Top module: `rtt_alarm_timer`

## Requirements
- R1: After reset, the four registers read back as follows: Control reads 0, Alarm reads 0xFFFFFFFF, Count reads 0 and Events reads 0. The interrupt output is low.
- R2: Control bits 15:0 hold the prescaler period, bit 16 enables the alarm interrupt and bit 17 enables the increment interrupt. These 18 bits read back as last written. Bit 18 is the restart command and always reads 0, as do bits 31:19.
- R3: The counter increments by exactly one after every P synchronized rising edges of the slow clock, where P is the programmed period. A period of 0 means 65536 edges, so a zero setting never advances the counter after a few hundred edges.
- R4: Writes to the Count register at 0x08 have no effect on the count.
- R5: Writing Control with bit 18 set clears the counter and the prescaler phase. Counting then resumes from zero, and a full period must elapse before the next increment.
- R6: The Alarm register at 0x04 is fully writable and reads back the value written. The all-ones value is its reset value.
- R7: Events bit 0 sets when an increment makes the counter equal to the Alarm value.
- R8: Events bit 1 sets on every counter increment.
- R9: A read of Events at 0x0C returns the flags and clears both of them. A flag that sets in the same cycle as that read stays set for the next read.
- R10: The interrupt output equals the OR of (Events bit 0 AND Control bit 16) and (Events bit 1 AND Control bit 17).
- R11: Writes to the Events register have no effect on the flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_clk | input | 1 | Slow time-base clock, asynchronous to clk |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte address; word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| irq | output | 1 | Level interrupt |

## Verification
Several properties are checked on every cycle:
- the counter changes by at most one per clock;
- a restart zeroes the counter;
- an increment always leaves the increment flag set, and an increment that lands on the alarm value leaves the alarm flag set;
- an Events read leaves both flags clear unless an increment landed in the same cycle;
- the interrupt is never high without a pending flag.

Some behaviour only the bench's scenarios can show: the exact number of slow edges per increment for each prescaler setting, the zero-means-65536 rule, ignored writes, and the same-cycle collision of a flag event with a clearing read.

// File: rtl/rtt_pkg.sv
package rtt_pkg;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned PRES_W    = 16;
  localparam int unsigned ADDR_W    = 4;
  localparam int unsigned N_FLAGS   = 2;

  // word index = bus_addr[3:2]
  localparam logic [1:0] W_CTRL  = 2'd0;
  localparam logic [1:0] W_ALARM = 2'd1;
  localparam logic [1:0] W_COUNT = 2'd2;
  localparam logic [1:0] W_EVENT = 2'd3;

  localparam int unsigned B_ALM_EN  = 16;
  localparam int unsigned B_INC_EN  = 17;
  localparam int unsigned B_RESTART = 18;
  localparam int unsigned CTRL_W    = B_INC_EN + 1;

  localparam int unsigned F_ALM = 0;
  localparam int unsigned F_INC = 1;
endpackage

// File: rtl/rtt_edge_sync.sv
module rtt_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic [STAGES:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q[0] <= 1'b0;
    else        chain_q[0] <= async_in;
  end

  for (genvar i = 1; i <= STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[i] <= 1'b0;
      else        chain_q[i] <= chain_q[i-1];
    end
  end

  assign rise = chain_q[STAGES-1] & ~chain_q[STAGES];
endmodule

// File: rtl/rtt_tick_counter.sv
module rtt_tick_counter #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned PRES_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              restart,
  input  logic [PRES_W-1:0] period,
  input  logic [DATA_W-1:0] alarm,
  output logic [DATA_W-1:0] value,
  output logic              inc_evt,
  output logic              alm_evt
);
  localparam logic [PRES_W-1:0] P_ONE = PRES_W'(1);
  localparam logic [DATA_W-1:0] C_ONE = DATA_W'(1);

  logic [PRES_W-1:0] phase_q, phase_d, last_phase;
  logic [DATA_W-1:0] value_d, value_inc;
  logic              cnt_en, at_end;

  // period 0 wraps to all ones: a full 2^PRES_W edge period
  assign last_phase = period - P_ONE;
  assign at_end     = (phase_q == last_phase);
  assign value_inc  = value + C_ONE;
  assign cnt_en     = restart | tick;

  always_comb begin
    phase_d = phase_q;
    value_d = value;
    inc_evt = 1'b0;
    alm_evt = 1'b0;
    if (restart) begin
      phase_d = '0;
      value_d = '0;
    end else if (tick) begin
      if (at_end) begin
        phase_d = '0;
        value_d = value_inc;
        inc_evt = 1'b1;
        alm_evt = (value_inc == alarm);
      end else begin
        phase_d = phase_q + P_ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      value   <= '0;
    end else if (cnt_en) begin
      phase_q <= phase_d;
      value   <= value_d;
    end
  end
endmodule

// File: rtl/rtt_event_flags.sv
module rtt_event_flags #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_vec,
  input  logic         clr,
  input  logic [N-1:0] enable,
  output logic [N-1:0] flags,
  output logic         irq
);
  logic [N-1:0] flags_d;

  // a new event outranks the clearing read
  assign flags_d = (flags & {N{~clr}}) | set_vec;
  assign irq     = |(flags & enable);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= flags_d;
  end
endmodule

// File: rtl/rtt_alarm_timer.sv
module rtt_alarm_timer
  import rtt_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_clk,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  logic [CTRL_W-1:0]  ctrl_q;
  logic [DATA_W-1:0]  alarm_q;
  logic [DATA_W-1:0]  value_q;
  logic [N_FLAGS-1:0] flags_q, set_vec, irq_en;
  logic               tick, restart, inc_evt, alm_evt;
  logic               aligned, wr_ctrl, wr_alarm, rd_event;
  logic [1:0]         word;
  logic               unused_wbits;

  assign word     = bus_addr[3:2];
  assign aligned  = (bus_addr[1:0] == 2'b00);
  assign wr_ctrl  = bus_sel &  bus_wr & aligned & (word == W_CTRL);
  assign wr_alarm = bus_sel &  bus_wr & aligned & (word == W_ALARM);
  assign rd_event = bus_sel & ~bus_wr & aligned & (word == W_EVENT);
  assign restart  = wr_ctrl & bus_wdata[B_RESTART];
  assign unused_wbits = ^bus_wdata[DATA_W-1:B_RESTART+1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= bus_wdata[CTRL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        alarm_q <= '1;
    else if (wr_alarm) alarm_q <= bus_wdata;
  end

  rtt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (slow_clk),
    .rise     (tick)
  );

  rtt_tick_counter #(.DATA_W(DATA_W), .PRES_W(PRES_W)) u_count (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .restart (restart),
    .period  (ctrl_q[PRES_W-1:0]),
    .alarm   (alarm_q),
    .value   (value_q),
    .inc_evt (inc_evt),
    .alm_evt (alm_evt)
  );

  always_comb begin
    set_vec        = '0;
    set_vec[F_ALM] = alm_evt;
    set_vec[F_INC] = inc_evt;
    irq_en         = '0;
    irq_en[F_ALM]  = ctrl_q[B_ALM_EN];
    irq_en[F_INC]  = ctrl_q[B_INC_EN];
  end

  rtt_event_flags #(.N(N_FLAGS)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .clr     (rd_event),
    .enable  (irq_en),
    .flags   (flags_q),
    .irq     (irq)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr && aligned) begin
      unique case (word)
        W_CTRL:  bus_rdata[CTRL_W-1:0]  = ctrl_q;
        W_ALARM: bus_rdata              = alarm_q;
        W_COUNT: bus_rdata              = value_q;
        W_EVENT: bus_rdata[N_FLAGS-1:0] = flags_q;
        default: bus_rdata              = '0;
      endcase
    end
  end
endmodule

// File: rtl/rtt_alarm_timer_chk.sv
module rtt_alarm_timer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_sel,
  input logic        bus_wr,
  input logic [3:0]  bus_addr,
  input logic [31:0] bus_wdata,
  input logic [31:0] bus_rdata,
  input logic        irq,
  input logic [31:0] cnt_value,
  input logic [31:0] alarm_val,
  input logic [1:0]  flags
);
  logic wr_restart, rd_event, rd_ctrl;
  assign wr_restart = bus_sel && bus_wr && (bus_addr == 4'h0) && bus_wdata[18];
  assign rd_event   = bus_sel && !bus_wr && (bus_addr == 4'hC);
  assign rd_ctrl    = bus_sel && !bus_wr && (bus_addr == 4'h0);

  p_restart_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_restart |=> (cnt_value == 32'd0));

  p_single_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_restart |=> (cnt_value == $past(cnt_value)) ||
                    (cnt_value == $past(cnt_value) + 32'd1));

  p_inc_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wr_restart) && (cnt_value != $past(cnt_value))) |-> flags[1]);

  p_alarm_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wr_restart) && (cnt_value != $past(cnt_value)) &&
     (cnt_value == $past(alarm_val))) |-> flags[0]);

  p_read_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_event |=> (cnt_value != $past(cnt_value)) || (flags == 2'b00));

  p_irq_has_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flags != 2'b00));

  p_ctrl_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ctrl |-> (bus_rdata[31:18] == 14'd0));
endmodule

bind rtt_alarm_timer rtt_alarm_timer_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .irq       (irq),
  .cnt_value (value_q),
  .alarm_val (alarm_q),
  .flags     (flags_q)
);

// File: tb/rtt_alarm_timer_tb_top.sv
`timescale 1ns/100ps
module rtt_alarm_timer_tb_top;
  logic        clk, rst_n, slow_clk;
  logic        bus_sel, bus_wr;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        irq;

  int unsigned n_chk, n_fail;
  bit          done;

  // reference model state
  logic [15:0] m_pres, m_ph;
  logic        m_alm_en, m_inc_en;
  logic [31:0] m_alarm, m_cnt;
  logic [1:0]  m_flags;

  rtt_alarm_timer dut_i (
    .clk(clk), .rst_n(rst_n), .slow_clk(slow_clk),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic exp_irq();
    return (m_flags[0] & m_alm_en) | (m_flags[1] & m_inc_en);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic slow_pulse();
    @(negedge clk); slow_clk = 1'b1;
    repeat (2) @(negedge clk);
    slow_clk = 1'b0;
    repeat (2) @(negedge clk);
    if (m_ph == m_pres - 16'd1) begin
      m_ph = '0;
      m_cnt = m_cnt + 32'd1;
      m_flags[1] = 1'b1;
      if (m_cnt == m_alarm) m_flags[0] = 1'b1;
    end else begin
      m_ph = m_ph + 16'd1;
    end
  endtask

  task automatic set_ctrl(input logic [15:0] p, input logic ae, input logic ie, input logic rs);
    bus_write(4'h0, {13'h0, rs, ie, ae, p});
    m_pres = p; m_alm_en = ae; m_inc_en = ie;
    if (rs) begin m_cnt = '0; m_ph = '0; end
  endtask

  task automatic read_events(input string tag);
    logic [31:0] d;
    bus_read(4'hC, d);
    check(tag, d, {30'd0, m_flags});
    m_flags = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h5EED_0A1A));
    n_chk = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; slow_clk = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
    bus_addr = '0; bus_wdata = '0;
    m_pres = '0; m_ph = '0; m_alm_en = 1'b0; m_inc_en = 1'b0;
    m_alarm = '1; m_cnt = '0; m_flags = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state, R6 alarm reset value
    bus_read(4'h0, d); check("R1 ctrl", d, 32'h0);
    bus_read(4'h4, d); check("R6 alarm reset", d, 32'hFFFF_FFFF);
    bus_read(4'h8, d); check("R1 count", d, 32'h0);
    bus_read(4'hC, d); check("R1 events", d, 32'h0);
    check("R1 irq", {31'd0, irq}, 32'h0);

    // R2 control readback, restart and upper bits read 0
    bus_write(4'h0, 32'hABC4_0003);
    m_pres = 16'd3; m_alm_en = 1'b0; m_inc_en = 1'b0; m_cnt = '0; m_ph = '0;
    bus_read(4'h0, d); check("R2 ctrl readback", d, 32'h0000_0003);
    set_ctrl(16'd2, 1'b1, 1'b1, 1'b0);
    bus_read(4'h0, d); check("R2 ctrl enables", d, 32'h0003_0002);

    // R6 alarm write/readback
    bus_write(4'h4, 32'h1234_5678); m_alarm = 32'h1234_5678;
    bus_read(4'h4, d); check("R6 alarm rw", d, 32'h1234_5678);

    // R3 counting at period 2, R8 increment flag, R4 count write ignored
    set_ctrl(16'd2, 1'b0, 1'b0, 1'b1);
    repeat (5) slow_pulse();
    bus_write(4'h8, 32'hDEAD_BEEF);
    bus_read(4'h8, d); check("R3 R4 count after 5 edges period 2", d, 32'd2);
    read_events("R8 inc flag");

    // R11 events write ignored while flags set
    slow_pulse();
    bus_write(4'hC, 32'h0);
    bus_write(4'hC, 32'h3);
    read_events("R11 events write ignored");
    bus_read(4'hC, d); check("R9 cleared by read", d, 32'h0);

    // R7 alarm match
    set_ctrl(16'd1, 1'b1, 1'b0, 1'b1);
    bus_write(4'h4, 32'd3); m_alarm = 32'd3;
    repeat (2) slow_pulse();
    bus_read(4'hC, d); check("R7 no alarm before match", d, 32'h2);
    m_flags = '0;
    slow_pulse();
    check("R10 irq on alarm", {31'd0, irq}, 32'h1);
    bus_read(4'hC, d); check("R7 alarm at match", d, 32'h3);
    m_flags = '0;
    check("R10 irq cleared", {31'd0, irq}, 32'h0);

    // R10 masking: flag pending, enables off then on
    set_ctrl(16'd1, 1'b0, 1'b0, 1'b0);
    slow_pulse();
    check("R10 masked", {31'd0, irq}, 32'h0);
    set_ctrl(16'd1, 1'b0, 1'b1, 1'b0);
    check("R10 unmasked", {31'd0, irq}, 32'h1);
    read_events("R8 flag pending");

    // R9 collision: read in the same cycle the increment lands
    set_ctrl(16'd1, 1'b0, 1'b0, 1'b1);
    @(negedge clk); slow_clk = 1'b1;
    repeat (2) @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 4'hC;
    @(negedge clk);
    bus_sel = 1'b0; slow_clk = 1'b0;
    repeat (2) @(negedge clk);
    bus_read(4'hC, d); check("R9 event survives same-cycle read", d, 32'h2);
    bus_read(4'h8, d); check("R3 count after collision", d, 32'd1);
    m_cnt = 32'd1; m_ph = '0; m_flags = '0;

    // R5 restart mid-phase
    set_ctrl(16'd3, 1'b0, 1'b0, 1'b1);
    repeat (2) slow_pulse();
    set_ctrl(16'd3, 1'b0, 1'b0, 1'b1);
    repeat (2) slow_pulse();
    bus_read(4'h8, d); check("R5 phase cleared", d, 32'd0);
    slow_pulse();
    bus_read(4'h8, d); check("R5 full period after restart", d, 32'd1);
    read_events("R5 events");

    // R3 period 0 = 65536 edges
    set_ctrl(16'd0, 1'b0, 1'b0, 1'b1);
    repeat (300) slow_pulse();
    bus_read(4'h8, d); check("R3 zero period no advance", d, 32'd0);
    read_events("R3 zero period no events");

    // random mix
    set_ctrl(16'd1, 1'b0, 1'b0, 1'b1);
    m_flags = '0;
    for (int i = 0; i < 400; i++) begin
      int unsigned op;
      op = $urandom % 8;
      case (op)
        0, 1, 2, 3: slow_pulse();
        4: begin bus_read(4'h8, d); check("R3 random count", d, m_cnt); end
        5: read_events("R7 R8 R9 random events");
        6: set_ctrl(16'(1 + $urandom % 4), 1'($urandom), 1'($urandom), 1'b1);
        default: begin
          m_alarm = m_cnt + 32'($urandom % 4);
          bus_write(4'h4, m_alarm);
        end
      endcase
      check("R10 random irq", {31'd0, irq}, {31'd0, exp_irq()});
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule